// File: doc/BRIEF.md
# Bitmask Immediate Encoder

This block decides whether a 64-bit constant can be carried as the packed immediate of a bitwise-logical instruction. It returns the compact three-field code if it can. Such an immediate is one element of 2, 4, 8, 16, 32 or 64 bits, copied across the whole operand. The element holds exactly one run of ones, and that run may wrap past the element's top bit. The code has a one-bit wide-element flag, a 6-bit rotate count and a 6-bit size-and-length field.

A request is a one-cycle strobe together with the constant and a width select. One clock later the block returns a result strobe, a legality verdict and the three fields. In narrow (32-bit) mode only the low half of the constant counts. A code generator or an assembler back end can use this block to choose between a one-instruction immediate form and a longer materialisation sequence.

Top module: `bitmask_imm_encoder`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. While `rst_n` is low, all outputs are held at zero.
- R2: A constant is legal when the operand equals one element of size e in {2,4,8,16,32,64}, repeated, and that element holds a single circular run of ones. 0x5555555555555555 is legal. 0x0000CCCC0000CCCC and 0x0A0A0A0A0A0A0A0A are illegal.
- R3: An operand of all zeros is reported illegal, and so is an operand of all ones, in both modes.
- R4: A run that wraps past bit e-1 of its element is legal. 0xFFFFFFFFFFFFFFFD gives flag 1, rotate 62, size field 62.
- R5: The block uses the smallest element size that repeats. The flag is 1 only for e = 64. The size field is the run length minus one, ORed with a prefix set by e: 0 for e=64 and e=32, 0b100000 for 16, 0b110000 for 8, 0b111000 for 4, 0b111100 for 2.
- R6: The rotate field r lies in 0..e-1. Rotating a run of L ones that starts at bit 0 right by r inside the element gives back the element.
- R7: When `in_wide` is 0, bits 63:32 of `in_value` are ignored. The low 32 bits are treated as the operand, repeated twice, and the flag is always 0.
- R8: All three fields are zero whenever `out_valid` or `out_legal` is low. `out_legal` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_value | input | 64 | Constant to encode |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_legal | output | 1 | Constant is encodable |
| out_n | output | 1 | Wide-element flag (element of 64 bits) |
| out_immr | output | 6 | Right-rotate count |
| out_imms | output | 6 | Size prefix ORed with run length minus one |

## Verification
A full sweep feeds every canonical code's decoded mask, in both modes. The returned code must match, which separates a wrong rotate or a wrong length from a wrong element-size choice. Directed constants cover the cases a single-run test can miss: periodic values with two runs per element, the wrapped near-all-ones value, and the zero and all-ones operands. Narrow-mode requests carry unrelated upper halves, which shows whether those bits leak into the verdict. Random constants, most of them illegal, are checked against a search model that works by rotation. Every accepted code is also decoded back and compared with the operand.

// File: rtl/bmi_pkg.sv
// Shared constants and the result record of the bitmask immediate encoder.
// Assumes a 64-bit operand; field widths follow from it.
package bmi_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned FIELD_W   = $clog2(WORD_W);
    localparam int unsigned NUM_SIZES = FIELD_W;

    typedef struct packed {
        logic               ok;
        logic               n;
        logic [FIELD_W-1:0] immr;
        logic [FIELD_W-1:0] imms;
    } bmi_enc_t;
endpackage

// File: rtl/bmi_period_detect.sv
// Finds the smallest power-of-two element size (2..WORD_W) whose copies
// rebuild the operand. Output is one-hot, bit k meaning size 2<<k.
// Assumes nothing about the operand; the full-width size always matches.
module bmi_period_detect
    import bmi_pkg::*;
(
    input  logic [WORD_W-1:0]    value,
    output logic [NUM_SIZES-1:0] size_onehot
);
    logic [2*WORD_W-1:0]  doubled;
    logic [NUM_SIZES-1:0] repeats;

    // Concatenate the value with itself so a slice gives a rotation.
    assign doubled = {value, value};

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_rot
        localparam int unsigned SZ = 2 << k;
        // The value repeats with period SZ when rotating by SZ leaves it unchanged.
        assign repeats[k] = (doubled[SZ +: WORD_W] == value);
    end

    // Keep only the lowest matching size.
    assign size_onehot = repeats & (~repeats + NUM_SIZES'(1));
endmodule

// File: rtl/bmi_run_analyze.sv
// Inspects one element of ELEM_W bits. Reports whether its ones form a
// single circular run, the right-rotate count that places a low-aligned
// run onto it, and the run length minus one.
// Assumes ELEM_W is a power of two no larger than WORD_W.
module bmi_run_analyze
    import bmi_pkg::*;
#(
    parameter int unsigned ELEM_W = 8
) (
    input  logic [ELEM_W-1:0]  elem,
    output logic               single_run,
    output logic [FIELD_W-1:0] rot,
    output logic [FIELD_W-1:0] len_m1
);
    int unsigned ones_cnt;
    int unsigned rise_cnt;
    int unsigned start_pos;

    // Count set bits and rising edges (a one whose circular lower neighbour is zero).
    always_comb begin
        ones_cnt  = 0;
        rise_cnt  = 0;
        start_pos = 0;
        for (int unsigned i = 0; i < ELEM_W; i++) begin
            ones_cnt = ones_cnt + 32'(elem[i]);
            if (elem[i] && !elem[(i + ELEM_W - 1) % ELEM_W]) begin
                rise_cnt  = rise_cnt + 1;
                start_pos = i;
            end
        end
    end

    // One edge exactly: excludes empty and full elements as well as split runs.
    assign single_run = (rise_cnt == 1);
    // A run starting at bit s comes from a right rotation of (ELEM_W - s) mod ELEM_W.
    assign rot        = FIELD_W'((ELEM_W - start_pos) % ELEM_W);
    assign len_m1     = (ones_cnt == 0) ? '0 : FIELD_W'(ones_cnt - 1);
endmodule

// File: rtl/bitmask_imm_encoder.sv
// Registered encoder for logical-instruction bitmask immediates.
// A request (in_valid) yields a verdict and the flag/rotate/size fields one
// clock later. Assumes a single-cycle strobe per request; requests may come
// back to back. Narrow mode repeats the low half of the constant.
module bitmask_imm_encoder
    import bmi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_value,
    input  logic               in_wide,
    output logic               out_valid,
    output logic               out_legal,
    output logic               out_n,
    output logic [FIELD_W-1:0] out_immr,
    output logic [FIELD_W-1:0] out_imms
);
    localparam int unsigned HALF_W = WORD_W / 2;

    logic [WORD_W-1:0]    operand;
    logic [NUM_SIZES-1:0] size_onehot;
    logic [NUM_SIZES-1:0] cand_ok;
    logic [FIELD_W-1:0]   cand_immr [NUM_SIZES];
    logic [FIELD_W-1:0]   cand_imms [NUM_SIZES];
    bmi_enc_t             sel;

    // Narrow requests see their low half repeated, so they never need the full-width element.
    assign operand = in_wide ? in_value : {in_value[HALF_W-1:0], in_value[HALF_W-1:0]};

    bmi_period_detect u_period (
        .value       (operand),
        .size_onehot (size_onehot)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int unsigned SZ  = 2 << k;
        localparam int unsigned PFX = (2 * WORD_W - 2 * SZ) % WORD_W;
        logic               run_ok;
        logic [FIELD_W-1:0] rot;
        logic [FIELD_W-1:0] len_m1;

        bmi_run_analyze #(.ELEM_W(SZ)) u_run (
            .elem       (operand[SZ-1:0]),
            .single_run (run_ok),
            .rot        (rot),
            .len_m1     (len_m1)
        );

        // Candidate code for this element size.
        assign cand_ok[k]   = run_ok;
        assign cand_immr[k] = rot;
        assign cand_imms[k] = FIELD_W'(PFX) | len_m1;
    end

    // Pick the candidate belonging to the detected element size.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (size_onehot[k]) begin
                sel.ok   = cand_ok[k];
                sel.n    = (k == NUM_SIZES - 1);
                sel.immr = cand_immr[k];
                sel.imms = cand_imms[k];
            end
        end
    end

    // Register the verdict; fields are zero unless a legal result is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_legal <= 1'b0;
            out_n     <= 1'b0;
            out_immr  <= '0;
            out_imms  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && sel.ok) begin
                out_legal <= 1'b1;
                out_n     <= sel.n;
                out_immr  <= sel.immr;
                out_imms  <= sel.imms;
            end else begin
                out_legal <= 1'b0;
                out_n     <= 1'b0;
                out_immr  <= '0;
                out_imms  <= '0;
            end
        end
    end
endmodule

// File: rtl/bitmask_imm_encoder_chk.sv
// Property checker for bitmask_imm_encoder, attached through bind.
// Assumes the synchronous active-low reset of the encoder.
module bitmask_imm_encoder_chk
    import bmi_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_wide,
    input logic               out_valid,
    input logic               out_legal,
    input logic               out_n,
    input logic [FIELD_W-1:0] out_immr,
    input logic [FIELD_W-1:0] out_imms
);
    assert_strobe_to_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_verdict_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_legal |-> out_valid);

    assert_fields_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_legal |-> (!out_n && out_immr == '0 && out_imms == '0));

    assert_narrow_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> !out_n);

    assert_full_run_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_legal && out_n) |-> (out_imms != '1));

    assert_reserved_size_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_legal && !out_n) |-> (out_imms[FIELD_W-1:1] != '1));

    assert_rot_within_element_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_legal && !out_n && !out_imms[FIELD_W-1]) |-> !out_immr[FIELD_W-1]);
endmodule

bind bitmask_imm_encoder bitmask_imm_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .out_valid (out_valid),
    .out_legal (out_legal),
    .out_n     (out_n),
    .out_immr  (out_immr),
    .out_imms  (out_imms)
);

// File: tb/bitmask_imm_encoder_test.sv
// Self-checking bench: a behavioural search model predicts each cycle's
// result, every accepted code is decoded back, and all canonical codes are swept.
module bitmask_imm_encoder_test;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 40000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_value;
    logic        in_wide;
    logic        out_valid;
    logic        out_legal;
    logic        out_n;
    logic [5:0]  out_immr;
    logic [5:0]  out_imms;

    int vectors = 0;
    int misses  = 0;
    bit mon_on  = 1'b0;
    bit done    = 1'b0;

    logic        exp_valid, exp_ok, exp_n;
    logic [5:0]  exp_immr, exp_imms;
    logic [63:0] exp_op;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitmask_imm_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_value  (in_value),
        .in_wide   (in_wide),
        .out_valid (out_valid),
        .out_legal (out_legal),
        .out_n     (out_n),
        .out_immr  (out_immr),
        .out_imms  (out_imms)
    );

    function automatic logic [63:0] low_ones(input int len);
        return (len >= 64) ? '1 : ((64'd1 << len) - 64'd1);
    endfunction

    function automatic logic [63:0] ror_in(input logic [63:0] x, input int e, input int r);
        logic [127:0] w;
        logic [63:0]  m;
        m = low_ones(e);
        w = {64'd0, x & m};
        if (r != 0) w = (w >> r) | (w << (e - r));
        return w[63:0] & m;
    endfunction

    function automatic logic [63:0] spread(input logic [63:0] elem, input int e);
        logic [63:0] v = '0;
        for (int p = 0; p < 64; p += e) v |= elem << p;
        return v;
    endfunction

    // Turn a code back into its mask; reserved codes give zero.
    function automatic logic [63:0] decode(input logic n, input logic [5:0] immr, input logic [5:0] imms);
        int e = 0;
        if (n) e = 64;
        else begin
            for (int b = 5; b >= 0; b--) begin
                if (!imms[b]) begin
                    e = 1 << b;
                    break;
                end
            end
        end
        if (e < 2) return '0;
        return spread(ror_in(low_ones(int'(imms) % e + 1), e, int'(immr) % e), e);
    endfunction

    // Search model: smallest repeating element, then try every rotation of a low run.
    task automatic ref_encode(input logic [63:0] v, input logic wide, output logic ok,
                              output logic n, output logic [5:0] immr, output logic [5:0] imms,
                              output logic [63:0] op);
        logic [63:0] elem;
        int len;
        ok = 0; n = 0; immr = 0; imms = 0;
        op = wide ? v : {v[31:0], v[31:0]};
        for (int e = 2; e <= 64; e *= 2) begin
            elem = op & low_ones(e);
            if (spread(elem, e) == op) begin
                len = $countones(elem);
                if (len == 0 || len == e) return;
                for (int r = 0; r < e; r++) begin
                    if (ror_in(low_ones(len), e, r) == elem) begin
                        ok   = 1;
                        n    = (e == 64);
                        immr = 6'(r);
                        imms = n ? 6'(len - 1) : (6'(~(2 * e - 1)) | 6'(len - 1));
                        return;
                    end
                end
                return;
            end
        end
    endtask

    // Cycle model: the result presented after this edge.
    always @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            exp_valid = rst_n ? in_valid : 1'b0;
            exp_ok = 0; exp_n = 0; exp_immr = 0; exp_imms = 0; exp_op = 0;
        end else begin
            exp_valid = 1'b1;
            ref_encode(in_value, in_wide, exp_ok, exp_n, exp_immr, exp_imms, exp_op);
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            vectors++;
            if (out_valid !== exp_valid) begin
                misses++;
                $display("FAIL R1 out_valid got %b expected %b", out_valid, exp_valid);
            end
            if (out_legal !== exp_ok) begin
                misses++;
                $display("FAIL R2 out_legal got %b expected %b for %h", out_legal, exp_ok, exp_op);
            end
            if ({out_n, out_immr, out_imms} !== {exp_n, exp_immr, exp_imms}) begin
                misses++;
                $display("FAIL %s fields got %b/%0d/%h expected %b/%0d/%h", exp_ok ? "R5" : "R8",
                         out_n, out_immr, out_imms, exp_n, exp_immr, exp_imms);
            end
            if (out_legal === 1'b1 && decode(out_n, out_immr, out_imms) !== exp_op) begin
                misses++;
                $display("FAIL R6 round trip got %h expected %h",
                         decode(out_n, out_immr, out_imms), exp_op);
            end
        end
    end

    task automatic drive(input logic [63:0] v, input logic w);
        @(negedge clk);
        in_valid = 1'b1;
        in_value = v;
        in_wide  = w;
    endtask

    // Directed request with literal expected values.
    task automatic known(input logic [63:0] v, input logic w, input logic ok, input logic n,
                         input logic [5:0] immr, input logic [5:0] imms, input string tag);
        drive(v, w);
        @(negedge clk);
        in_valid = 1'b0;
        vectors++;
        if ({out_valid, out_legal, out_n, out_immr, out_imms} !== {1'b1, ok, n, immr, imms}) begin
            misses++;
            $display("FAIL %s value %h wide %b got %b%b/%b/%0d/%h expected 1%b/%b/%0d/%h", tag, v, w,
                     out_valid, out_legal, out_n, out_immr, out_imms, ok, n, immr, imms);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_value = '1;
        in_wide  = 1'b1;
        repeat (3) @(negedge clk);
        vectors++;
        if ({out_valid, out_legal, out_n, out_immr, out_imms} !== '0) begin
            misses++;
            $display("FAIL R1 reset outputs got %b expected 0",
                     {out_valid, out_legal, out_n, out_immr, out_imms});
        end
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        mon_on   = 1'b1;

        known(64'h5555555555555555, 1, 1, 0, 6'd0, 6'h3C, "R2");
        known(64'h0000CCCC0000CCCC, 1, 0, 0, 6'd0, 6'h00, "R2");
        known(64'h0A0A0A0A0A0A0A0A, 1, 0, 0, 6'd0, 6'h00, "R2");
        known(64'h0, 1, 0, 0, 6'd0, 6'h00, "R3");
        known(64'hFFFFFFFFFFFFFFFF, 1, 0, 0, 6'd0, 6'h00, "R3");
        known(64'h00000000FFFFFFFF, 0, 0, 0, 6'd0, 6'h00, "R3");
        known(64'h9876543200000000, 0, 0, 0, 6'd0, 6'h00, "R3");
        known(64'hFFFFFFFFFFFFFFFD, 1, 1, 1, 6'd62, 6'd62, "R4");
        known(64'h8000000000000001, 1, 1, 1, 6'd1, 6'd1, "R4");
        known(64'h00000000FFFFFFFF, 1, 1, 1, 6'd0, 6'd31, "R5");
        known(64'h00FF00FF00FF00FF, 1, 1, 0, 6'd0, 6'h27, "R5");
        known(64'h0FF00FF00FF00FF0, 1, 1, 0, 6'd12, 6'h27, "R6");
        known(64'h8080808080808080, 1, 1, 0, 6'd1, 6'h30, "R6");
        known(64'hDEADBEEF00FF00FF, 0, 1, 0, 6'd0, 6'h27, "R7");
        known(64'h123456780000FFFF, 0, 1, 0, 6'd0, 6'h0F, "R7");

        // Sweep of canonical codes, wide mode (R5, R6).
        for (int k = 1; k <= 6; k++) begin
            for (int len = 1; len < (1 << k); len++) begin
                for (int r = 0; r < (1 << k); r++) begin
                    drive(spread(ror_in(low_ones(len), 1 << k, r), 1 << k), 1'b1);
                end
            end
        end
        // Sweep in narrow mode with unrelated upper halves (R7).
        for (int k = 1; k <= 5; k++) begin
            for (int len = 1; len < (1 << k); len++) begin
                for (int r = 0; r < (1 << k); r++) begin
                    drive({$urandom(), spread(ror_in(low_ones(len), 1 << k, r), 1 << k)[31:0]}, 1'b0);
                end
            end
        end
        // Random constants with gaps in the strobe (R1, R2).
        for (int i = 0; i < 600; i++) begin
            drive({$urandom(), $urandom()}, 1'($urandom()));
            if (i % 7 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule